// File: doc/BRIEF.md
# Rule-Constrained Level-1 Accept Generator

This block produces level-1 accept (L1A) strobes for a test stand. It times itself against an internal bunch-crossing counter. The counter wraps at a programmable orbit length. Internal trigger candidates come from one of two sources:
- a periodic schedule: a first slot at a programmable crossing, then a fixed spacing, with a limited number of slots per orbit;
- a pseudo-random source: a 32-bit LFSR value is compared with a rate threshold.

Orbit-level gating limits how many orbits carry triggers and can restart that pattern after a repeat period. Internal candidates that land in the gap at the end of each orbit are suppressed.

External requests also reach the trigger logic. They come from a falling edge on an external input and from a debounced push button. External requests bypass the schedule, the main enable and gap blanking. They remain subject to the link-state halt and to the four rate rules. Rule k (k = 1..4) allows at most k accepted triggers in any window of its programmed number of crossings. A trigger that would break a rule is dropped, and the counter of every rule it breaks advances. A 4-bit link state can halt all triggers when it is not Ready, after a programmable reaction delay.

All counting is qualified by a clock enable. A capture strobe copies the running count of accepted triggers into a readout register.

Top module: `l1a_trigger_gen`

## Requirements
- R1: The crossing counter runs 0..orbit_len-1 and then wraps. In periodic mode (rand_en=0) an enabled orbit yields a candidate at crossing trig_start and then every trig_spacing crossings (a spacing of 0 acts as 1). An orbit yields at most trigs_per_orbit candidates. Each accepted candidate gives one l1a pulse.
- R2: With burst_en=1 the per-orbit limit is one candidate, whatever trigs_per_orbit holds.
- R3: The orbit index counts from 0 while l1a_en=1. Candidates are allowed only while the index is below orbit_limit, and 0 means no limit. With repeat_en=1 and repeat_period=P>0, the index returns to 0 after P orbits.
- R4: With rand_en=1, an allowed crossing is a candidate when the LFSR value is strictly below rate_thresh. A threshold of 0 gives no triggers. The LFSR advances once per enabled clock.
- R5: Rule k reads its window W from rule_win[(k-1)*WIN_W +: WIN_W]. With W≠0, no W consecutive enabled crossings hold more than k pulses, and W=0 disables the rule. A request dropped by rules increments field k-1 (bits (k-1)*CNT_W +: CNT_W) of viol_count once for each rule it violates.
- R6: An internal candidate in the last gap_len crossings of the orbit is dropped unless blank_dis=1.
- R7: With bp_en=1, a link_state other than Ready (4'h8) that has persisted for bp_delay enabled clocks halts every trigger, internal and external. Triggers resume as soon as the state is Ready. Halted requests are not counted as rule violations.
- R8: Each falling edge on ext_trig_n yields exactly one request. This does not depend on l1a_en. The request is still subject to R5 and R7.
- R9: A button_n level must hold for DEBOUNCE clocks to be accepted. An accepted press (high to low) yields exactly one request, and shorter glitches are ignored.
- R10: A capture pulse copies the count of accepted triggers into trig_count_cap. That register otherwise holds its value.
- R11: While ce=0 no counter, LFSR or rule window advances and l1a stays low.
- R12: After reset l1a=0, trig_count_cap=0 and all viol_count fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Bunch-crossing clock enable |
| l1a_en | input | 1 | Main enable for internal triggers |
| burst_en | input | 1 | One candidate per orbit |
| repeat_en | input | 1 | Restart orbit pattern after repeat_period |
| bp_en | input | 1 | Enable link-state halt |
| rand_en | input | 1 | Select pseudo-random source |
| blank_dis | input | 1 | Disable orbit-gap blanking |
| orbit_len | input | BX_W | Crossings per orbit |
| trig_start | input | BX_W | Crossing of first periodic candidate |
| trig_spacing | input | BX_W | Crossings between periodic candidates |
| trigs_per_orbit | input | BX_W | Periodic candidates per orbit |
| orbit_limit | input | ORB_W | Orbits carrying triggers (0 = all) |
| repeat_period | input | ORB_W | Pattern period in orbits |
| gap_len | input | BX_W | Length of blanked orbit gap |
| rate_thresh | input | 32 | Random-mode threshold |
| rule_win | input | 4*WIN_W | Windows of rules 1..4 |
| bp_delay | input | DLY_W | Reaction delay to non-Ready link state |
| link_state | input | 4 | Link state, Ready = 4'h8 |
| ext_trig_n | input | 1 | External trigger, active falling edge |
| button_n | input | 1 | Push button, low when pressed |
| capture | input | 1 | Latch accepted-trigger count |
| l1a | output | 1 | Level-1 accept strobe |
| trig_count_cap | output | CNT_W | Captured accepted-trigger count |
| viol_count | output | 4*CNT_W | Per-rule drop counters |

## Verification
Periodic schedules are run with several spacings, starts and per-orbit counts. Burst, orbit limit, repeat and gap blanking are each switched against the same schedule, so a change in the count of pulses isolates one gate at a time. The random source is driven at zero, half and full threshold. With the full threshold every crossing is a candidate, so the count of pulses and the per-rule violation fields show which rule alone shapes the stream. External edges and button presses are applied both with the link Ready and with it busy, and in close pairs under a wide rule 1. This separates the halt from rule drops and tests single-request generation.

// File: rtl/trg_pkg.sv
package trg_pkg;
  localparam int unsigned NRULE      = 4;
  localparam logic [3:0]  LINK_READY = 4'h8;
  localparam int unsigned RND_W      = 32;
  // x^32 + x^22 + x^2 + x + 1, right-shift Galois form
  localparam logic [RND_W-1:0] RND_TAPS = 32'h8020_0003;
endpackage

// File: rtl/trg_orbit_sched.sv
module trg_orbit_sched
  import trg_pkg::*;
#(
  parameter int unsigned BX_W  = 12,
  parameter int unsigned ORB_W = 16,
  parameter logic [RND_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             l1a_en,
  input  logic             burst_en,
  input  logic             repeat_en,
  input  logic             rand_en,
  input  logic [BX_W-1:0]  orbit_len,
  input  logic [BX_W-1:0]  trig_start,
  input  logic [BX_W-1:0]  trig_spacing,
  input  logic [BX_W-1:0]  trigs_per_orbit,
  input  logic [ORB_W-1:0] orbit_limit,
  input  logic [ORB_W-1:0] repeat_period,
  input  logic [BX_W-1:0]  gap_len,
  input  logic [RND_W-1:0] rate_thresh,
  output logic             cand_o,
  output logic             in_gap_o
);
  logic [BX_W-1:0]  bx_q, bx_d;
  logic [BX_W-1:0]  sp_q, sp_d;
  logic [BX_W-1:0]  cnt_q, cnt_d;
  logic [ORB_W-1:0] orb_q, orb_d;
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             orbit_last, orb_ok, per_hit, rnd_hit;
  logic [BX_W-1:0]  sp_eff, n_lim;

  always_comb begin
    orbit_last = (orbit_len == '0) || (bx_q == orbit_len - BX_W'(1));
    bx_d       = orbit_last ? '0 : bx_q + BX_W'(1);
    sp_eff     = (trig_spacing == '0) ? BX_W'(1) : trig_spacing;
    n_lim      = burst_en ? BX_W'(1) : trigs_per_orbit;
    per_hit    = ((bx_q == trig_start) && (n_lim != '0)) ||
                 ((cnt_q != '0) && (cnt_q < n_lim) && (sp_q == '0));
    cnt_d = cnt_q;
    sp_d  = sp_q;
    if (orbit_last) begin
      cnt_d = '0;
      sp_d  = '0;
    end else if (per_hit) begin
      cnt_d = cnt_q + BX_W'(1);
      sp_d  = sp_eff - BX_W'(1);
    end else if (sp_q != '0) begin
      sp_d = sp_q - BX_W'(1);
    end
    orb_ok = (orbit_limit == '0) || (orb_q < orbit_limit);
    orb_d  = orb_q;
    if (!l1a_en) begin
      orb_d = '0;
    end else if (orbit_last) begin
      if (repeat_en && (repeat_period != '0) &&
          (orb_q >= repeat_period - ORB_W'(1)))
        orb_d = '0;
      else if (orb_q != '1)
        orb_d = orb_q + ORB_W'(1);
    end
    rnd_d    = {1'b0, rnd_q[RND_W-1:1]} ^ (rnd_q[0] ? RND_TAPS : '0);
    rnd_hit  = rnd_q < rate_thresh;
    cand_o   = l1a_en && orb_ok && (rand_en ? rnd_hit : per_hit);
    in_gap_o = (gap_len != '0) && (bx_q >= orbit_len - gap_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bx_q  <= '0;
      sp_q  <= '0;
      cnt_q <= '0;
      orb_q <= '0;
      rnd_q <= SEED;
    end else if (ce) begin
      bx_q  <= bx_d;
      sp_q  <= sp_d;
      cnt_q <= cnt_d;
      orb_q <= orb_d;
      rnd_q <= rnd_d;
    end
  end

  // R1: crossing counter never leaves the orbit
  a_r1_bx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (orbit_len != '0) |-> (bx_q < orbit_len));
endmodule

// File: rtl/trg_rule_window.sv
module trg_rule_window #(
  parameter int unsigned IDX   = 1,
  parameter int unsigned WIN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic [WIN_W-1:0] win,
  input  logic             fire,
  output logic             viol
);
  logic [WIN_W-1:0] age_q [IDX];
  logic [WIN_W-1:0] age_d [IDX];
  logic [IDX-1:0]   vld_q, vld_d;

  always_comb begin
    if (fire) begin
      age_d[0] = WIN_W'(1);
      vld_d[0] = 1'b1;
    end else begin
      age_d[0] = (age_q[0] == '1) ? age_q[0] : age_q[0] + WIN_W'(1);
      vld_d[0] = vld_q[0];
    end
    for (int k = 1; k < IDX; k++) begin
      if (fire) begin
        age_d[k] = (age_q[k-1] == '1) ? age_q[k-1] : age_q[k-1] + WIN_W'(1);
        vld_d[k] = vld_q[k-1];
      end else begin
        age_d[k] = (age_q[k] == '1) ? age_q[k] : age_q[k] + WIN_W'(1);
        vld_d[k] = vld_q[k];
      end
    end
    viol = (win != '0) && vld_q[IDX-1] && (age_q[IDX-1] < win);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int k = 0; k < IDX; k++) age_q[k] <= '0;
    end else if (ce) begin
      vld_q <= vld_d;
      for (int k = 0; k < IDX; k++) age_q[k] <= age_d[k];
    end
  end

  if (IDX == 1) begin : g_one
    // R5: single-trigger rule forbids back-to-back accepts
    a_r5_rule1_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && fire && (win > WIN_W'(1))) |=> !fire);
  end
endmodule

// File: rtl/trg_backpressure.sv
module trg_backpressure
  import trg_pkg::*;
#(
  parameter int unsigned DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             bp_en,
  input  logic [DLY_W-1:0] delay,
  input  logic [3:0]       link_state,
  output logic             halt
);
  logic             busy;
  logic [DLY_W-1:0] age_q, age_d;

  always_comb begin
    busy  = (link_state != LINK_READY);
    age_d = busy ? ((age_q == '1) ? age_q : age_q + DLY_W'(1)) : '0;
    halt  = bp_en && busy && (age_q >= delay);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  age_q <= '0;
    else if (ce) age_q <= age_d;
  end
endmodule

// File: rtl/trg_ext_input.sv
module trg_ext_input #(
  parameter int unsigned DEBOUNCE = 16,
  localparam int unsigned DEB_W = $clog2(DEBOUNCE + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce,
  input  logic ext_n,
  input  logic button_n,
  output logic req_o
);
  logic [2:0]       ext_sq;
  logic [1:0]       btn_sq;
  logic             btn_st_q, btn_st_d;
  logic [DEB_W-1:0] deb_q, deb_d;
  logic             fall, press, pend_d;

  always_comb begin
    fall     = ext_sq[2] && !ext_sq[1];
    btn_st_d = btn_st_q;
    deb_d    = '0;
    if (btn_sq[1] != btn_st_q) begin
      if (deb_q == DEB_W'(DEBOUNCE - 1)) btn_st_d = btn_sq[1];
      else                              deb_d    = deb_q + DEB_W'(1);
    end
    press  = btn_st_q && !btn_st_d;
    pend_d = (req_o && !ce) || fall || press;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_sq   <= '1;
      btn_sq   <= '1;
      btn_st_q <= 1'b1;
      deb_q    <= '0;
      req_o    <= 1'b0;
    end else begin
      ext_sq   <= {ext_sq[1:0], ext_n};
      btn_sq   <= {btn_sq[0], button_n};
      btn_st_q <= btn_st_d;
      deb_q    <= deb_d;
      req_o    <= pend_d;
    end
  end

  // R8: one edge produces a single request that is consumed at once
  a_r8_single_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && req_o) |=> !req_o);
endmodule

// File: rtl/l1a_trigger_gen.sv
module l1a_trigger_gen
  import trg_pkg::*;
#(
  parameter int unsigned BX_W     = 12,
  parameter int unsigned ORB_W    = 16,
  parameter int unsigned WIN_W    = 12,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned DLY_W    = 8,
  parameter int unsigned DEBOUNCE = 16,
  parameter logic [RND_W-1:0] SEED = 32'hACE1_2468
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce,
  input  logic                   l1a_en,
  input  logic                   burst_en,
  input  logic                   repeat_en,
  input  logic                   bp_en,
  input  logic                   rand_en,
  input  logic                   blank_dis,
  input  logic [BX_W-1:0]        orbit_len,
  input  logic [BX_W-1:0]        trig_start,
  input  logic [BX_W-1:0]        trig_spacing,
  input  logic [BX_W-1:0]        trigs_per_orbit,
  input  logic [ORB_W-1:0]       orbit_limit,
  input  logic [ORB_W-1:0]       repeat_period,
  input  logic [BX_W-1:0]        gap_len,
  input  logic [RND_W-1:0]       rate_thresh,
  input  logic [NRULE*WIN_W-1:0] rule_win,
  input  logic [DLY_W-1:0]       bp_delay,
  input  logic [3:0]             link_state,
  input  logic                   ext_trig_n,
  input  logic                   button_n,
  input  logic                   capture,
  output logic                   l1a,
  output logic [CNT_W-1:0]       trig_count_cap,
  output logic [NRULE*CNT_W-1:0] viol_count
);
  logic [1:0]       rst_sync;
  logic             rst_i;
  logic             cand, in_gap, ext_req, halt, req, fire, rule_drop;
  logic [NRULE-1:0] viol;
  logic [CNT_W-1:0] trig_q, trig_d, cap_d;
  logic [CNT_W-1:0] vcnt_q [NRULE];
  logic [CNT_W-1:0] vcnt_d [NRULE];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  trg_orbit_sched #(.BX_W(BX_W), .ORB_W(ORB_W), .SEED(SEED)) i_sched (
    .clk(clk), .rst_n(rst_i), .ce(ce), .l1a_en(l1a_en), .burst_en(burst_en),
    .repeat_en(repeat_en), .rand_en(rand_en), .orbit_len(orbit_len),
    .trig_start(trig_start), .trig_spacing(trig_spacing),
    .trigs_per_orbit(trigs_per_orbit), .orbit_limit(orbit_limit),
    .repeat_period(repeat_period), .gap_len(gap_len),
    .rate_thresh(rate_thresh), .cand_o(cand), .in_gap_o(in_gap));

  trg_ext_input #(.DEBOUNCE(DEBOUNCE)) i_ext (
    .clk(clk), .rst_n(rst_i), .ce(ce), .ext_n(ext_trig_n),
    .button_n(button_n), .req_o(ext_req));

  trg_backpressure #(.DLY_W(DLY_W)) i_bp (
    .clk(clk), .rst_n(rst_i), .ce(ce), .bp_en(bp_en), .delay(bp_delay),
    .link_state(link_state), .halt(halt));

  for (genvar g = 0; g < NRULE; g++) begin : g_rule
    trg_rule_window #(.IDX(g + 1), .WIN_W(WIN_W)) i_rule (
      .clk(clk), .rst_n(rst_i), .ce(ce),
      .win(rule_win[g*WIN_W +: WIN_W]), .fire(fire), .viol(viol[g]));
    assign viol_count[g*CNT_W +: CNT_W] = vcnt_q[g];
  end

  always_comb begin
    req       = ce && ((cand && !(in_gap && !blank_dis)) || ext_req);
    rule_drop = req && !halt && (viol != '0);
    fire      = req && !halt && (viol == '0);
    trig_d    = fire ? trig_q + CNT_W'(1) : trig_q;
    cap_d     = capture ? trig_q : trig_count_cap;
    for (int k = 0; k < NRULE; k++)
      vcnt_d[k] = (rule_drop && viol[k] && (vcnt_q[k] != '1)) ?
                  vcnt_q[k] + CNT_W'(1) : vcnt_q[k];
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      l1a            <= 1'b0;
      trig_q         <= '0;
      trig_count_cap <= '0;
      for (int k = 0; k < NRULE; k++) vcnt_q[k] <= '0;
    end else begin
      l1a            <= fire;
      trig_q         <= trig_d;
      trig_count_cap <= cap_d;
      for (int k = 0; k < NRULE; k++) vcnt_q[k] <= vcnt_d[k];
    end
  end

  // R7: a halted crossing never produces a strobe
  a_r7_halt_blocks: assert property (@(posedge clk) disable iff (!rst_i)
    (ce && halt) |=> !l1a);
  // R11: no strobe after a disabled crossing
  a_r11_idle_without_ce: assert property (@(posedge clk) disable iff (!rst_i)
    !ce |=> !l1a);
endmodule

// File: tb/test_l1a_trigger_gen.sv
module test_l1a_trigger_gen;
  logic        clk = 1'b0;
  logic        rst_n, ce, l1a_en, burst_en, repeat_en, bp_en, rand_en, blank_dis;
  logic [11:0] orbit_len, trig_start, trig_spacing, trigs_per_orbit, gap_len;
  logic [15:0] orbit_limit, repeat_period;
  logic [31:0] rate_thresh;
  logic [47:0] rule_win;
  logic [7:0]  bp_delay;
  logic [3:0]  link_state;
  logic        ext_trig_n, button_n, capture;
  logic        l1a;
  logic [15:0] trig_count_cap;
  logic [63:0] viol_count;
  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  l1a_trigger_gen i_l1a_trigger_gen (
    .clk(clk), .rst_n(rst_n), .ce(ce), .l1a_en(l1a_en), .burst_en(burst_en),
    .repeat_en(repeat_en), .bp_en(bp_en), .rand_en(rand_en),
    .blank_dis(blank_dis), .orbit_len(orbit_len), .trig_start(trig_start),
    .trig_spacing(trig_spacing), .trigs_per_orbit(trigs_per_orbit),
    .orbit_limit(orbit_limit), .repeat_period(repeat_period),
    .gap_len(gap_len), .rate_thresh(rate_thresh), .rule_win(rule_win),
    .bp_delay(bp_delay), .link_state(link_state), .ext_trig_n(ext_trig_n),
    .button_n(button_n), .capture(capture), .l1a(l1a),
    .trig_count_cap(trig_count_cap), .viol_count(viol_count));

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_default;
    ce = 1; l1a_en = 1; burst_en = 0; repeat_en = 0; bp_en = 0; rand_en = 0;
    blank_dis = 0; orbit_len = 100; trig_start = 10; trig_spacing = 7;
    trigs_per_orbit = 5; orbit_limit = 0; repeat_period = 0; gap_len = 0;
    rate_thresh = 0; rule_win = '0; bp_delay = 0; link_state = 4'h8;
    ext_trig_n = 1; button_n = 1; capture = 0;
  endtask

  task automatic do_reset;
    @(negedge clk) rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic count_l1a(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (l1a) c++;
    end
  endtask

  function automatic longint vf(input int k);
    return longint'(viol_count[k*16 +: 16]);
  endfunction

  task automatic t_reset;
    cfg_default(); l1a_en = 0;
    do_reset();
    @(negedge clk);
    check(l1a == 0, "R12 l1a", l1a, 0);
    check(trig_count_cap == 0, "R12 cap", trig_count_cap, 0);
    check(viol_count == '0, "R12 viol", viol_count, 0);
  endtask

  task automatic t_periodic;
    int c;
    cfg_default(); do_reset(); count_l1a(300, c);
    check(c == 15, "R1 periodic 5/orbit", c, 15);
    @(negedge clk) capture = 1;
    @(negedge clk) capture = 0;
    check(trig_count_cap == 15, "R10 capture", trig_count_cap, 15);
    count_l1a(50, c);
    check(trig_count_cap == 15, "R10 hold", trig_count_cap, 15);
    cfg_default(); trig_start = 3; trig_spacing = 0; trigs_per_orbit = 4;
    do_reset(); count_l1a(200, c);
    check(c == 8, "R1 spacing zero", c, 8);
  endtask

  task automatic t_burst;
    int c;
    cfg_default(); burst_en = 1; do_reset(); count_l1a(300, c);
    check(c == 3, "R2 burst", c, 3);
  endtask

  task automatic t_orbits;
    int c;
    cfg_default(); orbit_limit = 2; do_reset(); count_l1a(500, c);
    check(c == 10, "R3 orbit limit", c, 10);
    cfg_default(); orbit_limit = 1; repeat_en = 1; repeat_period = 3;
    do_reset(); count_l1a(600, c);
    check(c == 10, "R3 repeat", c, 10);
  endtask

  task automatic t_gap;
    int c;
    cfg_default(); gap_len = 20; trig_start = 75; trig_spacing = 5;
    do_reset(); count_l1a(300, c);
    check(c == 3, "R6 blanked", c, 3);
    blank_dis = 1; do_reset(); count_l1a(300, c);
    check(c == 15, "R6 blank disabled", c, 15);
  endtask

  task automatic t_random;
    int c;
    cfg_default(); rand_en = 1; rate_thresh = 0;
    do_reset(); count_l1a(300, c);
    check(c == 0, "R4 zero threshold", c, 0);
    rate_thresh = 32'h8000_0000; do_reset(); count_l1a(300, c);
    check(c > 90 && c < 210, "R4 half threshold", c, 150);
    rate_thresh = '1; do_reset(); count_l1a(300, c);
    check(c >= 298, "R4 full threshold", c, 300);
  endtask

  task automatic t_rules;
    int c;
    cfg_default(); rand_en = 1; rate_thresh = '1;
    rule_win = {12'd0, 12'd0, 12'd0, 12'd5};
    do_reset(); count_l1a(300, c);
    check(c >= 59 && c <= 61, "R5 rule1 w5", c, 60);
    check(vf(0) > 200, "R5 rule1 counter", vf(0), 240);
    check(vf(1) == 0, "R5 rule2 untouched", vf(1), 0);
    rule_win = {12'd0, 12'd0, 12'd10, 12'd0};
    do_reset(); count_l1a(300, c);
    check(c >= 58 && c <= 62, "R5 rule2 w10", c, 60);
    check(vf(0) == 0 && vf(1) > 200, "R5 rule2 counter", vf(1), 240);
    rule_win = {12'd20, 12'd0, 12'd0, 12'd0};
    do_reset(); count_l1a(300, c);
    check(c >= 58 && c <= 62, "R5 rule4 w20", c, 60);
    check(vf(3) > 200 && vf(2) == 0, "R5 rule4 counter", vf(3), 240);
  endtask

  task automatic t_bp;
    int c;
    cfg_default(); rand_en = 1; rate_thresh = '1; link_state = 4'h4;
    bp_en = 1; do_reset(); count_l1a(300, c);
    check(c == 0, "R7 halted", c, 0);
    bp_en = 0; do_reset(); count_l1a(300, c);
    check(c >= 298, "R7 bp disabled", c, 300);
    bp_en = 1; bp_delay = 10; do_reset(); count_l1a(300, c);
    check(c >= 9 && c <= 11, "R7 delayed halt", c, 10);
    link_state = 4'h8; count_l1a(100, c);
    check(c >= 98, "R7 resume on ready", c, 100);
  endtask

  task automatic t_ext;
    int c;
    cfg_default(); l1a_en = 0; do_reset(); c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (l1a) c++;
      ext_trig_n = !(i >= 5 && i < 10);
    end
    check(c == 1, "R8 single edge", c, 1);
    rule_win = {12'd0, 12'd0, 12'd0, 12'd20}; do_reset(); c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (l1a) c++;
      ext_trig_n = !((i >= 5 && i < 7) || (i >= 9 && i < 11));
    end
    check(c == 1, "R8 rule limits ext", c, 1);
    check(vf(0) == 1, "R8 ext rule drop counted", vf(0), 1);
    rule_win = '0; bp_en = 1; link_state = 4'h2; do_reset(); c = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (l1a) c++;
      ext_trig_n = !(i >= 5 && i < 10);
    end
    check(c == 0, "R8 ext halted", c, 0);
  endtask

  task automatic t_button;
    int c;
    cfg_default(); l1a_en = 0; do_reset(); c = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (l1a) c++;
      button_n = !(i >= 5 && i < 45);
    end
    check(c == 1, "R9 held press", c, 1);
    c = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (l1a) c++;
      button_n = !(i >= 5 && i < 10);
    end
    check(c == 0, "R9 glitch ignored", c, 0);
  endtask

  task automatic t_ce;
    int c;
    cfg_default(); rand_en = 1; rate_thresh = '1; ce = 0;
    do_reset(); count_l1a(100, c);
    check(c == 0, "R11 ce low", c, 0);
    @(negedge clk) capture = 1;
    @(negedge clk) capture = 0;
    check(trig_count_cap == 0, "R11 nothing counted", trig_count_cap, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    cfg_default();
    rst_n = 0;
    t_reset();
    t_periodic();
    t_burst();
    t_orbits();
    t_gap();
    t_random();
    t_rules();
    t_bp();
    t_ext();
    t_button();
    t_ce();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule